// File: doc/BRIEF.md
# One-Hot Matrix-Vector Multiplier

This block multiplies a programmable 3x3 matrix by a 3-component vector without any adder or multiplier. Every number travels in positional code: a component holding value k drives line k of its group and no other. Each element product is formed by steering the asserted vector line onto the product line for the right value. Each result is then decoded from the three products of its row. One three-input NAND term stands for each combination of product values, and each term is routed to the output line for its sum. The path from vector to result is purely combinational, so a result is available in the same cycle as the vector that produced it.

The nine matrix elements live in a small configuration file. A write port loads them one at a time in binary, and the stored values are converted to positional code internally. A vector component that is not a legal one-hot code raises an error flag, and all result lines are then forced low.

Top module: `omv_matvec_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, every matrix element reads as 0, so each result component shows value 0 for any legal vector.
- R2: A write with `wr_en` high and `wr_addr` = row*3+col (0 to 8) stores `wr_data` (binary 0 to 3) into element (row, col) at the rising clock edge. The new value affects results from that edge on.
- R3: A write with `wr_addr` from 9 to 15 changes no element.
- R4: While `wr_en` is low, no element changes, whatever `wr_addr` and `wr_data` hold.
- R5: Result component r on `y_out[r*28 +: 28]` asserts bit k alone, where k = sum over c of m[r][c]*v[c] (0 to 27). It follows a change of `vec_in` with no clock edge.
- R6: Vector component c is taken from `vec_in[c*4 +: 4]`, and bit k of that group stands for value k (0 to 3).
- R7: When any vector component has no line or more than one line asserted, `vec_err` is high and `y_out` is all zeros. Otherwise `vec_err` is low.
- R8: With `vec_err` low, every result component has exactly one line asserted.
- R9: A matrix with 0 on the diagonal and 1 elsewhere makes each output the sum of the two other inputs: y0=v1+v2, y1=v0+v2, y2=v0+v1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration file |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Element write enable |
| wr_addr | input | 4 | Element index, row*3+col |
| wr_data | input | 2 | Element value in binary |
| vec_in | input | 12 | Three one-hot vector components, 4 lines each |
| y_out | output | 84 | Three one-hot result components, 28 lines each |
| vec_err | output | 1 | Illegal vector code detected |

## Verification
A configuration write and a new vector can arrive in the same cycle. The combinational result must then use the old element until the clock edge and the new one after it. The bench provokes this by driving a write to element (0,0) together with a fresh vector after a falling edge. It compares result 0 against the old matrix before the rising edge and against the updated matrix just after it. The bench holds a binary reference model of the matrix and computes every expected sum from it. It sweeps all 64 legal vectors for each of several matrices.

// File: rtl/omv_pkg.sv
package omv_pkg;

  localparam int VAL_N_DEF  = 4;
  localparam int DIM_DEF    = 3;
  localparam int ADDR_W_DEF = 4;

  // Number of lines needed for a product of two values in 0..val_n-1.
  function automatic int prod_lines(input int val_n);
    return (val_n - 1) * (val_n - 1) + 1;
  endfunction

  // Number of lines needed for a sum of dim products.
  function automatic int sum_lines(input int val_n, input int dim);
    return dim * (prod_lines(val_n) - 1) + 1;
  endfunction

  // base**exp, for sizing the combination space.
  function automatic int ipow(input int base, input int exp);
    int acc;
    acc = 1;
    for (int i = 0; i < exp; i++) acc = acc * base;
    return acc;
  endfunction

  // Digit d of combination index g, written in radix base.
  function automatic int combo_digit(input int g, input int d, input int base);
    return (g / ipow(base, d)) % base;
  endfunction

  // Sum of all digits of combination index g.
  function automatic int combo_sum(input int g, input int dim, input int base);
    int acc;
    acc = 0;
    for (int d = 0; d < dim; d++) acc = acc + combo_digit(g, d, base);
    return acc;
  endfunction

endpackage

// File: rtl/omv_cfg_file.sv
module omv_cfg_file #(
  parameter int VAL_N  = omv_pkg::VAL_N_DEF,
  parameter int DIM    = omv_pkg::DIM_DEF,
  parameter int ADDR_W = omv_pkg::ADDR_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [$clog2(VAL_N)-1:0]     wr_data,
  output logic [DIM*DIM*$clog2(VAL_N)-1:0] cfg_q,
  output logic [DIM*DIM*VAL_N-1:0]     cfg_oh
);
  localparam int BIN_W  = $clog2(VAL_N);
  localparam int NUM_EL = DIM * DIM;

  logic [NUM_EL*BIN_W-1:0] cfg_d;
  logic [NUM_EL-1:0]       el_en;

  // Per-element clock enable: address must land inside the file.
  always_comb begin
    for (int e = 0; e < NUM_EL; e++) begin
      el_en[e] = wr_en && (wr_addr == ADDR_W'(e));
    end
  end

  // Next-state process.
  always_comb begin
    cfg_d = cfg_q;
    for (int e = 0; e < NUM_EL; e++) begin
      if (el_en[e]) cfg_d[e*BIN_W +: BIN_W] = wr_data;
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (|el_en) begin
      cfg_q <= cfg_d;
    end
  end

  // Binary to positional conversion, one decoder per element.
  for (genvar e = 0; e < NUM_EL; e++) begin : g_conv
    always_comb begin
      cfg_oh[e*VAL_N +: VAL_N] = '0;
      for (int k = 0; k < VAL_N; k++) begin
        if (cfg_q[e*BIN_W +: BIN_W] == BIN_W'(k)) cfg_oh[e*VAL_N + k] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/omv_in_stage.sv
module omv_in_stage #(
  parameter int VAL_N = omv_pkg::VAL_N_DEF,
  parameter int DIM   = omv_pkg::DIM_DEF
) (
  input  logic [DIM*VAL_N-1:0] vec_in,
  output logic [DIM*VAL_N-1:0] vec_n,
  output logic                 vec_err
);
  logic [DIM-1:0] comp_bad;

  for (genvar c = 0; c < DIM; c++) begin : g_comp
    logic [VAL_N-1:0] grp;
    assign grp         = vec_in[c*VAL_N +: VAL_N];
    assign comp_bad[c] = ($countones(grp) != 1);
  end

  // First stage: inverted copies of every input line.
  assign vec_n   = ~vec_in;
  assign vec_err = |comp_bad;

endmodule

// File: rtl/omv_elem_mul.sv
module omv_elem_mul #(
  parameter int VAL_N = omv_pkg::VAL_N_DEF
) (
  input  logic [VAL_N-1:0]                       a_n,
  input  logic [VAL_N-1:0]                       b_n,
  output logic [omv_pkg::prod_lines(VAL_N)-1:0]  prod
);
  localparam int PROD_N = omv_pkg::prod_lines(VAL_N);

  // Steering: the line pair (i, j) lands on product line i*j.
  always_comb begin
    prod = '0;
    for (int i = 0; i < VAL_N; i++) begin
      for (int j = 0; j < VAL_N; j++) begin
        prod[i*j] = prod[i*j] | ~(a_n[i] | b_n[j]);
      end
    end
  end

endmodule

// File: rtl/omv_row_sum.sv
module omv_row_sum #(
  parameter int VAL_N = omv_pkg::VAL_N_DEF,
  parameter int DIM   = omv_pkg::DIM_DEF
) (
  input  logic [DIM*omv_pkg::prod_lines(VAL_N)-1:0]     prods,
  output logic [omv_pkg::sum_lines(VAL_N, DIM)-1:0]     sum_oh
);
  localparam int PROD_N  = omv_pkg::prod_lines(VAL_N);
  localparam int SUM_N   = omv_pkg::sum_lines(VAL_N, DIM);
  localparam int N_COMBO = omv_pkg::ipow(PROD_N, DIM);

  logic [N_COMBO-1:0] term_n;

  // One NAND term per combination of product values.
  for (genvar g = 0; g < N_COMBO; g++) begin : g_term
    logic [DIM-1:0] hit;
    for (genvar d = 0; d < DIM; d++) begin : g_pick
      localparam int DIG = omv_pkg::combo_digit(g, d, PROD_N);
      assign hit[d] = prods[d*PROD_N + DIG];
    end
    assign term_n[g] = ~&hit;
  end

  // Second stage: route each term to the line of its sum.
  always_comb begin
    sum_oh = '0;
    for (int g = 0; g < N_COMBO; g++) begin
      sum_oh[omv_pkg::combo_sum(g, DIM, PROD_N)] =
        sum_oh[omv_pkg::combo_sum(g, DIM, PROD_N)] | ~term_n[g];
    end
  end

endmodule

// File: rtl/omv_matvec_top.sv
module omv_matvec_top #(
  parameter int VAL_N  = omv_pkg::VAL_N_DEF,
  parameter int DIM    = omv_pkg::DIM_DEF,
  parameter int ADDR_W = omv_pkg::ADDR_W_DEF
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         wr_en,
  input  logic [ADDR_W-1:0]                            wr_addr,
  input  logic [$clog2(VAL_N)-1:0]                     wr_data,
  input  logic [DIM*VAL_N-1:0]                         vec_in,
  output logic [DIM*omv_pkg::sum_lines(VAL_N, DIM)-1:0] y_out,
  output logic                                         vec_err
);
  localparam int BIN_W  = $clog2(VAL_N);
  localparam int NUM_EL = DIM * DIM;
  localparam int PROD_N = omv_pkg::prod_lines(VAL_N);
  localparam int SUM_N  = omv_pkg::sum_lines(VAL_N, DIM);

  logic [NUM_EL*BIN_W-1:0] cfg_q;
  logic [NUM_EL*VAL_N-1:0] cfg_oh;
  logic [NUM_EL*VAL_N-1:0] cfg_n;
  logic [DIM*VAL_N-1:0]    vec_n;

  omv_cfg_file #(.VAL_N(VAL_N), .DIM(DIM), .ADDR_W(ADDR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .cfg_oh  (cfg_oh)
  );

  omv_in_stage #(.VAL_N(VAL_N), .DIM(DIM)) u_in (
    .vec_in  (vec_in),
    .vec_n   (vec_n),
    .vec_err (vec_err)
  );

  assign cfg_n = ~cfg_oh;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic [DIM*PROD_N-1:0] prods;
    logic [SUM_N-1:0]      sum_oh;

    for (genvar c = 0; c < DIM; c++) begin : g_col
      omv_elem_mul #(.VAL_N(VAL_N)) u_mul (
        .a_n  (cfg_n[(r*DIM + c)*VAL_N +: VAL_N]),
        .b_n  (vec_n[c*VAL_N +: VAL_N]),
        .prod (prods[c*PROD_N +: PROD_N])
      );
    end

    omv_row_sum #(.VAL_N(VAL_N), .DIM(DIM)) u_sum (
      .prods  (prods),
      .sum_oh (sum_oh)
    );

    assign y_out[r*SUM_N +: SUM_N] = vec_err ? '0 : sum_oh;
  end

endmodule

// File: rtl/omv_matvec_chk.sv
module omv_matvec_chk #(
  parameter int VAL_N  = omv_pkg::VAL_N_DEF,
  parameter int DIM    = omv_pkg::DIM_DEF,
  parameter int ADDR_W = omv_pkg::ADDR_W_DEF
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         wr_en,
  input logic [ADDR_W-1:0]                            wr_addr,
  input logic [$clog2(VAL_N)-1:0]                     wr_data,
  input logic [DIM*VAL_N-1:0]                         vec_in,
  input logic [DIM*omv_pkg::sum_lines(VAL_N, DIM)-1:0] y_out,
  input logic                                         vec_err,
  input logic [DIM*DIM*$clog2(VAL_N)-1:0]             cfg_q
);
  localparam int BIN_W  = $clog2(VAL_N);
  localparam int NUM_EL = DIM * DIM;
  localparam int SUM_N  = omv_pkg::sum_lines(VAL_N, DIM);

  // R1: file is empty on the first cycle after reset release.
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_q == '0);

  // R2: a legal write lands in the addressed element.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(NUM_EL)) |=>
      cfg_q[int'($past(wr_addr))*BIN_W +: BIN_W] == $past(wr_data));

  // R3: out-of-range address leaves the file untouched.
  a_r3_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(NUM_EL)) |=> $stable(cfg_q));

  // R4: no enable, no change.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  // R7: error forces the result low.
  a_r7_err_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> y_out == '0);

  for (genvar c = 0; c < DIM; c++) begin : g_in
    // R7: an illegal component code is flagged.
    a_r7_err_detect: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(vec_in[c*VAL_N +: VAL_N]) != 1) |-> vec_err);
  end

  for (genvar r = 0; r < DIM; r++) begin : g_out
    // R8: one line per legal result component.
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_err |-> $countones(y_out[r*SUM_N +: SUM_N]) == 1);
  end

endmodule

bind omv_matvec_top omv_matvec_chk #(.VAL_N(VAL_N), .DIM(DIM), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/omv_matvec_top_bench.sv
module omv_matvec_top_bench;
  localparam int DIM   = 3;
  localparam int VAL_N = 4;
  localparam int SUM_N = 28;
  localparam int NTBL  = 6;

  // Each row: m00..m22, v0, v1, v2, y0, y1, y2.
  localparam int TBL [NTBL][15] = '{
    '{3,3,3, 3,3,3, 3,3,3,  3,3,3,  27,27,27},
    '{1,0,0, 0,1,0, 0,0,1,  2,0,3,  2,0,3},
    '{0,1,1, 1,0,1, 1,1,0,  1,2,3,  5,4,3},
    '{1,2,3, 0,1,2, 3,0,1,  3,2,1,  10,4,10},
    '{2,2,2, 3,3,3, 0,0,0,  1,1,3,  10,15,0},
    '{3,0,1, 2,3,0, 1,1,1,  0,3,2,  2,9,5}
  };

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   wr_en;
  logic [3:0]             wr_addr;
  logic [1:0]             wr_data;
  logic [DIM*VAL_N-1:0]   vec_in;
  logic [DIM*SUM_N-1:0]   y_out;
  logic                   vec_err;

  int n_checks = 0;
  int n_errors = 0;
  int mref [9];

  always #5 clk = ~clk;

  omv_matvec_top u_omv_matvec_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vec_in(vec_in), .y_out(y_out), .vec_err(vec_err)
  );

  function automatic logic [DIM*VAL_N-1:0] enc(input int v0, input int v1, input int v2);
    logic [DIM*VAL_N-1:0] x;
    x = '0;
    x[0*VAL_N + v0] = 1'b1;
    x[1*VAL_N + v1] = 1'b1;
    x[2*VAL_N + v2] = 1'b1;
    return x;
  endfunction

  function automatic int dec(input logic [SUM_N-1:0] x);
    int idx;
    if ($countones(x) != 1) return -1;
    idx = 0;
    for (int k = 0; k < SUM_N; k++) if (x[k]) idx = k;
    return idx;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_row(input int r, input int exp, input string tag);
    int act;
    act = dec(y_out[r*SUM_N +: SUM_N]);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic write_el(input int addr, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 2'(val);
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 9) mref[addr] = val;
  endtask

  task automatic check_ref(input int v0, input int v1, input int v2, input string tag);
    int vv [3];
    vv = '{v0, v1, v2};
    for (int r = 0; r < DIM; r++) begin
      int s;
      s = 0;
      for (int c = 0; c < DIM; c++) s += mref[r*DIM + c] * vv[c];
      chk_row(r, s, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vec_in = enc(1, 2, 3);
    for (int e = 0; e < 9; e++) mref[e] = 0;
    repeat (3) @(negedge clk);
    // R1: during reset every result reads 0.
    for (int r = 0; r < DIM; r++) chk_row(r, 0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    for (int r = 0; r < DIM; r++) chk_row(r, 0, "R1 after release");
    chk(vec_err == 1'b0, "R7 legal vector no flag", int'(vec_err), 0);

    // R2 R5 R6 R9: table walk, then full vector sweep per matrix.
    for (int t = 0; t < NTBL; t++) begin
      for (int e = 0; e < 9; e++) write_el(e, TBL[t][e]);
      @(negedge clk);
      vec_in = enc(TBL[t][9], TBL[t][10], TBL[t][11]);
      #1;
      for (int r = 0; r < DIM; r++) chk_row(r, TBL[t][12 + r], "R2 R5 R9 table");
      for (int g = 0; g < 64; g++) begin
        @(negedge clk);
        vec_in = enc(g % 4, (g / 4) % 4, g / 16);
        #1;
        check_ref(g % 4, (g / 4) % 4, g / 16, "R5 R6 sweep");
      end
    end

    // Matrix now holds table row 5; vector (1,1,1).
    @(negedge clk);
    vec_in = enc(1, 1, 1); #1;
    check_ref(1, 1, 1, "R5 baseline");

    // R3: writes to addresses 9..15 change nothing.
    for (int a = 9; a < 16; a++) write_el(a, 2);
    #1;
    check_ref(1, 1, 1, "R3 bad address ignored");

    // R4: address and data wiggle with enable low.
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 4'd0; wr_data = 2'd0;
    @(negedge clk);
    wr_addr = 4'd4; wr_data = 2'd1;
    @(negedge clk); #1;
    check_ref(1, 1, 1, "R4 no enable");

    // R2 R5: write and new vector in the same cycle.
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 2'd1;
    vec_in = enc(3, 2, 0);
    #1;
    check_ref(3, 2, 0, "R5 old element before edge");
    @(posedge clk); #1;
    wr_en = 1'b0;
    mref[0] = 1;
    check_ref(3, 2, 0, "R2 new element after edge");

    // R7: component with no line.
    @(negedge clk);
    vec_in = enc(1, 1, 1);
    vec_in[0 +: VAL_N] = '0; #1;
    chk(vec_err == 1'b1, "R7 empty component flag", int'(vec_err), 1);
    chk(y_out == '0, "R7 empty component blank", $countones(y_out), 0);
    // R7: component with two lines.
    @(negedge clk);
    vec_in = enc(1, 1, 1);
    vec_in[VAL_N +: VAL_N] = 4'b0110; #1;
    chk(vec_err == 1'b1, "R7 double line flag", int'(vec_err), 1);
    chk(y_out == '0, "R7 double line blank", $countones(y_out), 0);
    // R8: legal vector restores one line per component.
    @(negedge clk);
    vec_in = enc(2, 3, 1); #1;
    chk(vec_err == 1'b0, "R7 flag clears", int'(vec_err), 0);
    for (int r = 0; r < DIM; r++)
      chk($countones(y_out[r*SUM_N +: SUM_N]) == 1, "R8 one line",
          $countones(y_out[r*SUM_N +: SUM_N]), 1);

    // R1: mid-run reset clears the file at once.
    @(negedge clk);
    rst_n = 1'b0; #1;
    for (int e = 0; e < 9; e++) mref[e] = 0;
    for (int r = 0; r < DIM; r++) chk_row(r, 0, "R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_ref(2, 3, 1, "R1 stays clear");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule